// File: doc/BRIEF.md
# PWM Fault Brake Controller

This block watches a set of fault sources and decides when the two PWM output channels must leave their normal waveform and take a programmed safe state. The sources are two analog-comparator outputs, one external brake pin chosen from four, a combined system-fail input built from four individually enabled failure signals, and two software trigger strobes. The pin is selected, optionally inverted and then passed through a digital debounce filter. Its sample clock is the block clock divided by a power of two.

Each of the four hardware sources can feed an edge path, a level path, or both. The edge path latches on a rising qualified input and stays braked until software clears the edge flag. The level path follows the qualified input and releases only at a PWM period boundary once the input has gone inactive. A per-channel action is chosen for each path. The edge path wins when both paths are active. All inputs are single-cycle control signals that are synchronous to `clk`. There is no data stream and no handshake. Configuration inputs are expected to be held static while in use.

Top module: `pwm_fault_brake`

## Requirements
- R1: After reset both brake paths are inactive, both flags and `irq` are 0, and `pwm_out` equals `pwm_in`.
- R2: Source bit order in `edge_en` and `level_en` is: bit0 comparator 0, bit1 comparator 1, bit2 brake pin, bit3 system-fail. A rising edge on a source whose `edge_en` bit is set sets `edge_flag`, one clock later. A source whose enable bit is clear has no effect.
- R3: The edge brake equals `edge_flag`. It stays active while the source stays high, and until an `edge_clr` pulse clears it.
- R4: While any source enabled in `level_en` is high, `level_flag` and the level brake are set. The level brake is released only on a clock with `period_tick` high and no active level source.
- R5: Action codes are 0 invert the normal PWM level, 1 keep the normal level, 2 drive 0, and 3 drive 1. Channel 0 uses bits [1:0] of `edge_act` or `level_act`, and channel 1 uses bits [3:2].
- R6: When both brakes are active, each channel applies its `edge_act` code.
- R7: The pin source is `brk_pins[pin_sel]` XOR `pin_inv`. Pins that are not selected have no effect.
- R8: With debounce enabled, a new pin level is accepted only after it has differed from the accepted level on `dbc_len`+1 consecutive sample ticks. Sample ticks occur every 2^`dbc_div` clocks. A shorter pulse is rejected.
- R9: With `dbc_en` at 0, the pin level reaches the detectors with no filtering.
- R10: The system-fail source is the OR of `sys_fail & sys_fail_en`. A failure whose enable bit is clear has no effect.
- R11: A `sw_edge_trig` pulse acts as an edge-path event. A `sw_level_trig` pulse acts as an active level input for that clock.
- R12: `irq` is (`edge_flag` & `edge_ie`) | (`level_flag` & `level_ie`). The clear pulses are write-1 strobes. A set and a clear in the same clock leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_in | input | 2 | Comparator 0 and 1 outputs |
| brk_pins | input | 4 | External brake pins |
| pin_sel | input | 2 | Brake pin select |
| pin_inv | input | 1 | Invert selected pin (detect low / falling) |
| dbc_en | input | 1 | Debounce filter enable |
| dbc_div | input | 3 | Sample clock divider exponent |
| dbc_len | input | 3 | Required stable sample count minus one |
| sys_fail | input | 4 | Clock-fail, brown-out, lockup, RAM parity |
| sys_fail_en | input | 4 | Per-failure enables |
| edge_en | input | 4 | Edge-path source enables |
| level_en | input | 4 | Level-path source enables |
| sw_edge_trig | input | 1 | Software edge brake strobe |
| sw_level_trig | input | 1 | Software level brake strobe |
| period_tick | input | 1 | PWM period boundary pulse |
| edge_clr | input | 1 | Clear edge flag strobe |
| level_clr | input | 1 | Clear level flag strobe |
| edge_ie | input | 1 | Edge interrupt enable |
| level_ie | input | 1 | Level interrupt enable |
| edge_act | input | 4 | Edge-path action per channel |
| level_act | input | 4 | Level-path action per channel |
| pwm_in | input | 2 | Normal PWM levels |
| pwm_out | output | 2 | Channel outputs after braking |
| edge_brk | output | 1 | Edge brake active |
| level_brk | output | 1 | Level brake active |
| edge_flag | output | 1 | Edge interrupt flag |
| level_flag | output | 1 | Level interrupt flag |
| irq | output | 1 | Combined interrupt request |

## Verification
All four action codes are applied to both PWM input levels from a table. This shows that "invert" and "keep" follow the input, while "drive" ignores it. A comparator that is held high shows the difference between the latched edge path and the period-released level path. Overlapping brakes with conflicting actions expose the priority. The pin tests cover several cases: a pin that is not selected, inversion, a pulse shorter than the filter, and a divided sample clock. Together they tell apart selection, polarity, rejection and tick-rate faults.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  typedef enum logic [1:0] {
    ACT_INVERT = 2'd0,
    ACT_KEEP   = 2'd1,
    ACT_LOW    = 2'd2,
    ACT_HIGH   = 2'd3
  } brk_act_e;

  localparam int NSRC = 4;
  localparam int SRC_CMP0 = 0;
  localparam int SRC_CMP1 = 1;
  localparam int SRC_PIN  = 2;
  localparam int SRC_SYS  = 3;
endpackage

// File: rtl/pfb_debounce.sv
module pfb_debounce #(
  parameter int DIV_W = 3,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic [LEN_W-1:0] len,
  output logic             filt
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             tick;
  logic [LEN_W-1:0] run_q;
  logic             lvl_q;

  assign mask = ~({PRE_W{1'b1}} << div);
  assign tick = ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else if (!en) begin
      run_q <= '0;
      lvl_q <= raw;
    end else if (tick) begin
      if (raw == lvl_q) begin
        run_q <= '0;
      end else if (run_q == len) begin
        run_q <= '0;
        lvl_q <= raw;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign filt = en ? lvl_q : raw;

  // R8
  filt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> (!en || $stable(lvl_q)));
endmodule

// File: rtl/pfb_brake_path.sv
module pfb_brake_path
  import pfb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] edge_en,
  input  logic [NSRC-1:0] level_en,
  input  logic            sw_edge,
  input  logic            sw_level,
  input  logic            period_tick,
  input  logic            edge_clr,
  input  logic            level_clr,
  output logic            edge_flag,
  output logic            level_flag,
  output logic            level_brk
);
  logic [NSRC-1:0] prev_q;
  logic            edge_hit;
  logic            lvl_now;
  logic            eflag_q, lflag_q, lbrk_q;

  assign edge_hit = (|(src & ~prev_q & edge_en)) | sw_edge;
  assign lvl_now  = (|(src & level_en)) | sw_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      eflag_q <= 1'b0;
      lflag_q <= 1'b0;
      lbrk_q  <= 1'b0;
    end else begin
      prev_q <= src;
      if (edge_hit)      eflag_q <= 1'b1;
      else if (edge_clr) eflag_q <= 1'b0;
      if (lvl_now)        lflag_q <= 1'b1;
      else if (level_clr) lflag_q <= 1'b0;
      if (lvl_now)          lbrk_q <= 1'b1;
      else if (period_tick) lbrk_q <= 1'b0;
    end
  end

  assign edge_flag  = eflag_q;
  assign level_flag = lflag_q;
  assign level_brk  = lbrk_q;

  // R3
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eflag_q && !edge_clr) |=> eflag_q);
  // R4
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lbrk_q && !period_tick) |=> lbrk_q);
endmodule

// File: rtl/pfb_chan_out.sv
module pfb_chan_out
  import pfb_pkg::*;
(
  input  logic       pwm_lvl,
  input  logic       edge_on,
  input  logic       level_on,
  input  logic [1:0] edge_code,
  input  logic [1:0] level_code,
  output logic       out
);
  brk_act_e sel;

  always_comb begin
    sel = edge_on ? brk_act_e'(edge_code) : brk_act_e'(level_code);
    out = pwm_lvl;
    if (edge_on || level_on) begin
      unique case (sel)
        ACT_INVERT: out = ~pwm_lvl;
        ACT_KEEP:   out = pwm_lvl;
        ACT_LOW:    out = 1'b0;
        ACT_HIGH:   out = 1'b1;
        default:    out = pwm_lvl;
      endcase
    end
  end
endmodule

// File: rtl/pwm_fault_brake.sv
module pwm_fault_brake
  import pfb_pkg::*;
#(
  parameter int NPIN  = 4,
  parameter int NSYS  = 4,
  parameter int NCH   = 2,
  parameter int DIV_W = 3,
  parameter int LEN_W = 3,
  localparam int SEL_W = $clog2(NPIN),
  localparam int ACT_W = 2 * NCH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmp_in,
  input  logic [NPIN-1:0]  brk_pins,
  input  logic [SEL_W-1:0] pin_sel,
  input  logic             pin_inv,
  input  logic             dbc_en,
  input  logic [DIV_W-1:0] dbc_div,
  input  logic [LEN_W-1:0] dbc_len,
  input  logic [NSYS-1:0]  sys_fail,
  input  logic [NSYS-1:0]  sys_fail_en,
  input  logic [NSRC-1:0]  edge_en,
  input  logic [NSRC-1:0]  level_en,
  input  logic             sw_edge_trig,
  input  logic             sw_level_trig,
  input  logic             period_tick,
  input  logic             edge_clr,
  input  logic             level_clr,
  input  logic             edge_ie,
  input  logic             level_ie,
  input  logic [ACT_W-1:0] edge_act,
  input  logic [ACT_W-1:0] level_act,
  input  logic [NCH-1:0]   pwm_in,
  output logic [NCH-1:0]   pwm_out,
  output logic             edge_brk,
  output logic             level_brk,
  output logic             edge_flag,
  output logic             level_flag,
  output logic             irq
);
  logic            pin_raw;
  logic            pin_filt;
  logic [NSRC-1:0] src;

  assign pin_raw = brk_pins[pin_sel] ^ pin_inv;

  pfb_debounce #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_dbc (
    .clk(clk), .rst_n(rst_n), .raw(pin_raw), .en(dbc_en),
    .div(dbc_div), .len(dbc_len), .filt(pin_filt)
  );

  assign src[SRC_CMP0] = cmp_in[0];
  assign src[SRC_CMP1] = cmp_in[1];
  assign src[SRC_PIN]  = pin_filt;
  assign src[SRC_SYS]  = |(sys_fail & sys_fail_en);

  pfb_brake_path u_path (
    .clk(clk), .rst_n(rst_n), .src(src), .edge_en(edge_en),
    .level_en(level_en), .sw_edge(sw_edge_trig), .sw_level(sw_level_trig),
    .period_tick(period_tick), .edge_clr(edge_clr), .level_clr(level_clr),
    .edge_flag(edge_flag), .level_flag(level_flag), .level_brk(level_brk)
  );

  assign edge_brk = edge_flag;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pfb_chan_out u_ch (
      .pwm_lvl(pwm_in[c]), .edge_on(edge_brk), .level_on(level_brk),
      .edge_code(edge_act[2*c +: 2]), .level_code(level_act[2*c +: 2]),
      .out(pwm_out[c])
    );
  end

  assign irq = (edge_flag & edge_ie) | (level_flag & level_ie);

  // R1
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_brk && !level_brk) |-> (pwm_out == pwm_in));
  // R12
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_flag && !level_flag) |-> !irq);
endmodule

// File: tb/pwm_fault_brake_test.sv
module pwm_fault_brake_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] cmp_in = 0;
  logic [3:0] brk_pins = 0;
  logic [1:0] pin_sel = 0;
  logic       pin_inv = 0, dbc_en = 0;
  logic [2:0] dbc_div = 0, dbc_len = 0;
  logic [3:0] sys_fail = 0, sys_fail_en = 0, edge_en = 0, level_en = 0;
  logic       sw_edge_trig = 0, sw_level_trig = 0, period_tick = 0;
  logic       edge_clr = 0, level_clr = 0, edge_ie = 0, level_ie = 0;
  logic [3:0] edge_act = 0, level_act = 0;
  logic [1:0] pwm_in = 0;
  logic [1:0] pwm_out;
  logic       edge_brk, level_brk, edge_flag, level_flag, irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_fault_brake uut (.*);

  // {action, pwm level, expected output}
  localparam logic [3:0] VEC [0:7] = '{
    4'b00_0_1, 4'b00_1_0, 4'b01_0_0, 4'b01_1_1,
    4'b10_0_0, 4'b10_1_0, 4'b11_0_1, 4'b11_1_1
  };

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    edge_clr = 1; level_clr = 1; period_tick = 1;
    step(1);
    edge_clr = 0; level_clr = 0; period_tick = 0;
    step(1);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    pwm_in = 2'b10;
    step(2);
    // R1 reset state
    chk("R1", {edge_brk, level_brk, edge_flag, level_flag, irq}, 0);
    chk("R1", pwm_out, 2'b10);

    // R5 action table via software edge trigger (R11)
    for (int i = 0; i < 8; i++) begin
      edge_act = {VEC[i][3:2], VEC[i][3:2]};
      pwm_in = {VEC[i][1], VEC[i][1]};
      sw_edge_trig = 1;
      step(1);
      sw_edge_trig = 0;
      chk("R5", pwm_out, {VEC[i][0], VEC[i][0]});
      clear_all();
      chk("R11", pwm_out, {VEC[i][1], VEC[i][1]});
    end

    // R2 disabled source ignored, then enabled comparator latches
    pwm_in = 2'b00; edge_act = 4'b1111; level_act = 4'b1010;
    cmp_in = 2'b10; step(2);
    chk("R2", edge_flag, 0);
    cmp_in = 0; step(1);
    edge_en = 4'b0001; cmp_in = 2'b01; step(1);
    chk("R2", {edge_flag, pwm_out}, 3'b111);
    // R3 stays latched while high, period tick does nothing
    period_tick = 1; step(1); period_tick = 0; step(3);
    chk("R3", edge_brk, 1);
    edge_clr = 1; step(1); edge_clr = 0;
    chk("R3", {edge_brk, pwm_out}, 3'b000);
    cmp_in = 0; edge_en = 0; step(1);

    // R4 level follows comparator 1, released on period tick only
    level_en = 4'b0010; cmp_in = 2'b10; step(1);
    chk("R4", {level_brk, level_flag}, 2'b11);
    period_tick = 1; step(1); period_tick = 0;
    chk("R4", level_brk, 1);
    cmp_in = 0; step(3);
    chk("R4", level_brk, 1);
    period_tick = 1; step(1); period_tick = 0;
    chk("R4", {level_brk, level_flag}, 2'b01);
    level_clr = 1; step(1); level_clr = 0;
    chk("R12", level_flag, 0);

    // R6 edge priority: edge drives high, level drives low
    pwm_in = 2'b01; edge_act = 4'b1111; level_act = 4'b1010;
    sw_level_trig = 1; step(1);
    chk("R6", pwm_out, 2'b00);
    sw_edge_trig = 1; step(1); sw_edge_trig = 0; sw_level_trig = 0;
    chk("R6", pwm_out, 2'b11);
    clear_all(); level_en = 0;

    // R10 system fail enables
    sys_fail_en = 4'b0100; level_en = 4'b1000;
    sys_fail = 4'b0001; step(2);
    chk("R10", level_brk, 0);
    sys_fail = 4'b0100; step(1);
    chk("R10", level_brk, 1);
    sys_fail = 0; clear_all(); level_en = 0;

    // R7 / R9 pin select and invert, debounce bypassed
    brk_pins = 4'hF; pin_sel = 2; pin_inv = 1; step(2);
    edge_en = 4'b0100; step(1);
    clear_all();
    brk_pins = 4'b1101; step(2);
    chk("R7", edge_flag, 0);
    brk_pins = 4'b1001; step(1);
    chk("R9", edge_flag, 1);
    brk_pins = 4'hF; step(1); clear_all();

    // R8 short pulse rejected (div 0, len 3)
    dbc_en = 1; dbc_div = 0; dbc_len = 3; step(2);
    clear_all();
    brk_pins = 4'b1011; step(2); brk_pins = 4'hF; step(10);
    chk("R8", edge_flag, 0);
    // R8 exact acceptance with len 2: flag after 4 clocks, not 3
    dbc_len = 2;
    brk_pins = 4'b1011; step(3);
    chk("R8", edge_flag, 0);
    step(1);
    chk("R8", edge_flag, 1);
    brk_pins = 4'hF; step(6); clear_all();
    // R8 divided sample clock: div 2, len 1 -> between 6 and 9 clocks
    dbc_div = 2; dbc_len = 1; step(10); clear_all();
    brk_pins = 4'b1011; step(4);
    chk("R8", edge_flag, 0);
    step(6);
    chk("R8", edge_flag, 1);
    brk_pins = 4'hF; step(12); edge_en = 0; dbc_en = 0; clear_all();

    // R12 interrupt enables and set-wins-over-clear
    sw_edge_trig = 1; step(1); sw_edge_trig = 0;
    chk("R12", irq, 0);
    edge_ie = 1; step(1);
    chk("R12", irq, 1);
    edge_clr = 1; sw_edge_trig = 1; step(1);
    edge_clr = 0; sw_edge_trig = 0;
    chk("R12", edge_flag, 1);
    edge_clr = 1; step(1); edge_clr = 0;
    chk("R12", irq, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule